// File: doc/BRIEF.md
# Retired-Branch Hotspot Detector

This block observes branches only after they leave the retirement stage of a processor back end. It finds code regions that run often, and it needs no compiler hints, marker bits or rebuilt binaries, so any existing instruction stream can be profiled. Wrong-path and squashed branches never reach it, which means they never affect its state.

A direct-mapped table records branches. Each slot is selected by the low bits of the branch address and holds the remaining address bits as a tag, a small saturating execution count and a candidate flag. A slot becomes a candidate once its count reaches a threshold inside a rolling window of retired branches. At the end of each window every count is wiped, but the candidate flags stay. A separate detection counter falls by two for each retired candidate and climbs by one for each retired non-candidate, and it cannot rise above a start value that software programs. When this counter reaches zero, the block raises a request to a software handler. Table updates then stop until the handler acknowledges, and during that time software can inspect any slot through a read port. A clear command empties the table by visiting one slot per cycle, and busy is high while the clear runs.

Top module: `hsd_hotspot_detector`

## Requirements
- R1: After reset, hot_req and busy are low and every slot reads back with rd_valid low, count 0 and candidate flag low.
- R2: A retired branch whose slot is valid and whose tag matches adds one to the slot count. The count saturates at 2**CNT_W-1.
- R3: Slot index is ret_pc[IDX_W-1:0] and the tag is the remaining upper bits. A tag miss on an invalid slot or a non-candidate slot refills it with the new tag, count 1 and candidate flag low. A tag miss on a candidate slot leaves that slot unchanged.
- R4: The candidate flag is set by the hit that brings the count up to THRESH. The flag then stays set until a clear.
- R5: The branch that completes each group of 2**WIN_W accepted branches causes every count to read 0 afterwards, while candidate flags and tags are kept.
- R6: The detection counter starts at hot_start. It falls by 2 (floor 0) for a retired branch that hit a slot already flagged as candidate, and otherwise rises by 1, capped at hot_start. hot_req is high in the cycle after the counter reaches 0.
- R7: hot_req stays high until ack is seen. ack then drops hot_req on the next cycle and reloads the detection counter with hot_start.
- R8: A retired branch is ignored while hot_req or busy is high, and also when ret_valid is low.
- R9: A clear_req pulse sets busy high for exactly DEPTH cycles, starting the next cycle, and drops any pending hot_req. Afterwards every slot is invalid with count 0 and candidate flag low, and the window and detection counters are restarted.
- R10: rd_valid, rd_tag, rd_cnt and rd_cand show the slot chosen by rd_idx in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ret_valid | input | 1 | A branch retired this cycle |
| ret_pc | input | ADDR_W | Address of the retired branch |
| hot_start | input | HOT_W | Start and ceiling value of the detection counter |
| ack | input | 1 | Handler acknowledge |
| clear_req | input | 1 | Start a clear of all state |
| rd_idx | input | IDX_W | Slot selected for read-back |
| hot_req | output | 1 | Request to the software handler |
| busy | output | 1 | Clear in progress |
| rd_valid | output | 1 | Selected slot holds a branch |
| rd_tag | output | ADDR_W-IDX_W | Tag of the selected slot |
| rd_cnt | output | CNT_W | Execution count of the selected slot |
| rd_cand | output | 1 | Candidate flag of the selected slot |

## Verification
The bench builds the block with an 8-slot table, 16-bit addresses, a 3-bit count, a threshold of 4, a 32-branch window and a detection start value of 10. These small sizes make each corner short to reach. Count saturation takes seven hits, and two tags share one slot so that both the refill case and the protected-candidate case occur. A window rollover happens after about thirty branches, and a full clear sweep can be counted cycle by cycle. The detection counter's saturation, its reaching zero, the freeze during a pending request and the reload after an acknowledge all happen inside one short vector table plus a few directed sequences.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

   // controller state of the detector
   typedef enum logic [1:0] {
      CTL_RUN   = 2'd0,
      CTL_HOLD  = 2'd1,
      CTL_SWEEP = 2'd2
   } ctl_e;

   // outcome of looking a retired branch up in its slot
   typedef enum logic [1:0] {
      LK_HIT  = 2'd0,
      LK_FILL = 2'd1,
      LK_KEEP = 2'd2
   } lookup_e;

endpackage

// File: rtl/hsd_entry_table.sv
module hsd_entry_table #(
   parameter int DEPTH = 4096,
   parameter int IDX_W = 12,
   parameter int TAG_W = 20,
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] lk_idx,
   output logic             lk_vld,
   output logic             lk_cand,
   output logic [TAG_W-1:0] lk_tag,
   output logic [CNT_W-1:0] lk_cnt,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [CNT_W-1:0] wr_cnt,
   input  logic             wr_cand,
   input  logic             clr_en,
   input  logic [IDX_W-1:0] clr_idx,
   input  logic             flash,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_vld,
   output logic             rd_cand,
   output logic [TAG_W-1:0] rd_tag,
   output logic [CNT_W-1:0] rd_cnt
);

   logic             vld_q  [DEPTH];
   logic             cand_q [DEPTH];
   logic [TAG_W-1:0] tag_q  [DEPTH];
   logic [CNT_W-1:0] cnt_q  [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            vld_q[i]  <= 1'b0;
            cand_q[i] <= 1'b0;
            tag_q[i]  <= '0;
            cnt_q[i]  <= '0;
         end
      end else begin
         if (clr_en) begin
            vld_q[clr_idx]  <= 1'b0;
            cand_q[clr_idx] <= 1'b0;
            tag_q[clr_idx]  <= '0;
            cnt_q[clr_idx]  <= '0;
         end else if (wr_en) begin
            vld_q[wr_idx]  <= 1'b1;
            cand_q[wr_idx] <= wr_cand;
            tag_q[wr_idx]  <= wr_tag;
            cnt_q[wr_idx]  <= wr_cnt;
         end
         // window rollover wipes every count, later assignment wins
         if (flash) begin
            for (int i = 0; i < DEPTH; i++) begin
               cnt_q[i] <= '0;
            end
         end
      end
   end

   assign lk_vld  = vld_q[lk_idx];
   assign lk_cand = cand_q[lk_idx];
   assign lk_tag  = tag_q[lk_idx];
   assign lk_cnt  = cnt_q[lk_idx];

   assign rd_vld  = vld_q[rd_idx];
   assign rd_cand = cand_q[rd_idx];
   assign rd_tag  = tag_q[rd_idx];
   assign rd_cnt  = cnt_q[rd_idx];

endmodule

// File: rtl/hsd_update_logic.sv
module hsd_update_logic
   import hsd_pkg::*;
#(
   parameter int TAG_W  = 20,
   parameter int CNT_W  = 5,
   parameter int THRESH = 16
) (
   input  logic             lk_vld,
   input  logic             lk_cand,
   input  logic [TAG_W-1:0] lk_tag,
   input  logic [CNT_W-1:0] lk_cnt,
   input  logic [TAG_W-1:0] br_tag,
   output lookup_e          kind,
   output logic [CNT_W-1:0] new_cnt,
   output logic             new_cand,
   output logic             hit_cand
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_THR = CNT_W'(THRESH);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic             hit;
   logic [CNT_W-1:0] inc_cnt;

   assign hit     = lk_vld && (lk_tag == br_tag);
   assign inc_cnt = (lk_cnt == CNT_MAX) ? CNT_MAX : lk_cnt + CNT_ONE;

   always_comb begin
      kind     = LK_KEEP;
      new_cnt  = lk_cnt;
      new_cand = lk_cand;
      if (hit) begin
         kind     = LK_HIT;
         new_cnt  = inc_cnt;
         new_cand = lk_cand || (inc_cnt >= CNT_THR);
      end else if (!lk_vld || !lk_cand) begin
         kind     = LK_FILL;
         new_cnt  = CNT_ONE;
         new_cand = 1'b0;
      end
   end

   assign hit_cand = hit && lk_cand;

endmodule

// File: rtl/hsd_window_ctr.sv
module hsd_window_ctr #(
   parameter int WIN_W = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic step,
   output logic wrap
);

   logic [WIN_W-1:0] pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (restart) begin
         pos_q <= '0;
      end else if (step) begin
         pos_q <= pos_q + WIN_W'(1);
      end
   end

   assign wrap = step && !restart && (&pos_q);

endmodule

// File: rtl/hsd_hot_ctr.sv
module hsd_hot_ctr #(
   parameter int HOT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [HOT_W-1:0] start,
   input  logic             load,
   input  logic             step,
   input  logic             is_cand,
   output logic             zero_nxt
);

   localparam logic [HOT_W-1:0] TWO = HOT_W'(2);
   localparam logic [HOT_W-1:0] ONE = HOT_W'(1);

   logic [HOT_W-1:0] lvl_q;
   logic [HOT_W-1:0] lvl_nxt;

   always_comb begin
      if (is_cand) begin
         lvl_nxt = (lvl_q <= TWO) ? '0 : lvl_q - TWO;
      end else begin
         lvl_nxt = (lvl_q >= start) ? start : lvl_q + ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= start;
      end else if (load) begin
         lvl_q <= start;
      end else if (step) begin
         lvl_q <= lvl_nxt;
      end
   end

   assign zero_nxt = step && (lvl_nxt == '0);

endmodule

// File: rtl/hsd_hotspot_detector.sv
module hsd_hotspot_detector
   import hsd_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 4096,
   parameter int CNT_W  = 5,
   parameter int THRESH = 16,
   parameter int WIN_W  = 12,
   parameter int HOT_W  = 16,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int TAG_W = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ret_valid,
   input  logic [ADDR_W-1:0] ret_pc,
   input  logic [HOT_W-1:0]  hot_start,
   input  logic              ack,
   input  logic              clear_req,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              hot_req,
   output logic              busy,
   output logic              rd_valid,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [CNT_W-1:0]  rd_cnt,
   output logic              rd_cand
);

   // elaboration-time parameter checks
   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (THRESH < 2 || THRESH > (1 << CNT_W) - 1) begin : g_bad_thresh
      $error("THRESH must lie in 2 .. 2**CNT_W-1");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("ADDR_W must exceed the index width");
   end
   if (WIN_W < 2 || HOT_W < 2) begin : g_bad_ctr
      $error("counter widths must be at least 2");
   end

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

   ctl_e             st_q, st_d;
   logic [IDX_W-1:0] ptr_q;

   logic [IDX_W-1:0] br_idx;
   logic [TAG_W-1:0] br_tag;
   logic             acc, clear_go, ack_go;

   logic             lk_vld, lk_cand;
   logic [TAG_W-1:0] lk_tag;
   logic [CNT_W-1:0] lk_cnt;
   lookup_e          kind;
   logic [CNT_W-1:0] new_cnt;
   logic             new_cand, hit_cand;
   logic             wrap, zero_nxt;

   assign br_idx = ret_pc[IDX_W-1:0];
   assign br_tag = ret_pc[ADDR_W-1:IDX_W];

   assign acc      = ret_valid && (st_q == CTL_RUN) && !clear_req;
   assign clear_go = clear_req && (st_q != CTL_SWEEP);
   assign ack_go   = ack && (st_q == CTL_HOLD);

   hsd_entry_table #(
      .DEPTH (DEPTH),
      .IDX_W (IDX_W),
      .TAG_W (TAG_W),
      .CNT_W (CNT_W)
   ) i_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .lk_idx  (br_idx),
      .lk_vld  (lk_vld),
      .lk_cand (lk_cand),
      .lk_tag  (lk_tag),
      .lk_cnt  (lk_cnt),
      .wr_en   (acc && (kind != LK_KEEP)),
      .wr_idx  (br_idx),
      .wr_tag  (br_tag),
      .wr_cnt  (new_cnt),
      .wr_cand (new_cand),
      .clr_en  (st_q == CTL_SWEEP),
      .clr_idx (ptr_q),
      .flash   (wrap),
      .rd_idx  (rd_idx),
      .rd_vld  (rd_valid),
      .rd_cand (rd_cand),
      .rd_tag  (rd_tag),
      .rd_cnt  (rd_cnt)
   );

   hsd_update_logic #(
      .TAG_W  (TAG_W),
      .CNT_W  (CNT_W),
      .THRESH (THRESH)
   ) i_update (
      .lk_vld   (lk_vld),
      .lk_cand  (lk_cand),
      .lk_tag   (lk_tag),
      .lk_cnt   (lk_cnt),
      .br_tag   (br_tag),
      .kind     (kind),
      .new_cnt  (new_cnt),
      .new_cand (new_cand),
      .hit_cand (hit_cand)
   );

   hsd_window_ctr #(
      .WIN_W (WIN_W)
   ) i_window (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (clear_go),
      .step    (acc),
      .wrap    (wrap)
   );

   hsd_hot_ctr #(
      .HOT_W (HOT_W)
   ) i_hot (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (hot_start),
      .load     (clear_go || ack_go),
      .step     (acc),
      .is_cand  (hit_cand),
      .zero_nxt (zero_nxt)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         CTL_RUN: begin
            if (clear_go) begin
               st_d = CTL_SWEEP;
            end else if (acc && zero_nxt) begin
               st_d = CTL_HOLD;
            end
         end
         CTL_HOLD: begin
            if (clear_go) begin
               st_d = CTL_SWEEP;
            end else if (ack_go) begin
               st_d = CTL_RUN;
            end
         end
         CTL_SWEEP: begin
            if (ptr_q == LAST_IDX) begin
               st_d = CTL_RUN;
            end
         end
         default: st_d = CTL_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= CTL_RUN;
         ptr_q <= '0;
      end else begin
         st_q <= st_d;
         if (clear_go) begin
            ptr_q <= '0;
         end else if (st_q == CTL_SWEEP) begin
            ptr_q <= ptr_q + IDX_W'(1);
         end
      end
   end

   assign hot_req = (st_q == CTL_HOLD);
   assign busy    = (st_q == CTL_SWEEP);

endmodule

// File: rtl/hsd_checker.sv
module hsd_checker #(
   parameter int DEPTH  = 4096,
   parameter int IDX_W  = 12,
   parameter int TAG_W  = 20,
   parameter int CNT_W  = 5,
   parameter int THRESH = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ack,
   input logic             clear_req,
   input logic             hot_req,
   input logic             busy,
   input logic [IDX_W-1:0] rd_idx,
   input logic             rd_valid,
   input logic [TAG_W-1:0] rd_tag,
   input logic [CNT_W-1:0] rd_cnt,
   input logic             rd_cand
);

   // length of the current busy stretch, checked when busy falls
   logic [IDX_W+1:0] busy_len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_len_q <= '0;
      end else if (busy) begin
         busy_len_q <= busy_len_q + (IDX_W+2)'(1);
      end else begin
         busy_len_q <= '0;
      end
   end

   // R7: a pending request is held until acknowledged or cleared
   p_hold_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hot_req && !ack && !clear_req) |=> hot_req);

   // R7: acknowledge drops the request one cycle later
   p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hot_req && ack) |=> !hot_req);

   // R9: a clear keeps busy high for exactly DEPTH cycles
   p_busy_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_len_q == (IDX_W+2)'(DEPTH)));

   // R4: a slot whose count reached the threshold is a candidate
   p_cand_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && (rd_cnt >= CNT_W'(THRESH))) |-> rd_cand);

   // R8: the table is frozen while a request is pending
   p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hot_req && !ack && !clear_req) |=>
         ((rd_idx != $past(rd_idx)) ||
          ($stable(rd_cnt) && $stable(rd_tag) && $stable(rd_cand) && $stable(rd_valid))));

endmodule

bind hsd_hotspot_detector hsd_checker #(
   .DEPTH  (DEPTH),
   .IDX_W  (IDX_W),
   .TAG_W  (TAG_W),
   .CNT_W  (CNT_W),
   .THRESH (THRESH)
) i_hsd_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .ack       (ack),
   .clear_req (clear_req),
   .hot_req   (hot_req),
   .busy      (busy),
   .rd_idx    (rd_idx),
   .rd_valid  (rd_valid),
   .rd_tag    (rd_tag),
   .rd_cnt    (rd_cnt),
   .rd_cand   (rd_cand)
);

// File: tb/test_hsd_hotspot_detector.sv
`timescale 1ns/1ps
module test_hsd_hotspot_detector;

   localparam int ADDR_W = 16;
   localparam int DEPTH  = 8;
   localparam int CNT_W  = 3;
   localparam int THRESH = 4;
   localparam int WIN_W  = 5;
   localparam int HOT_W  = 6;
   localparam int IDX_W  = 3;
   localparam int TAG_W  = ADDR_W - IDX_W;

   // vector: pc[20:5], expected count[4:2], candidate[1], hot_req[0]
   localparam int NVEC = 12;
   localparam logic [20:0] VECS [NVEC] = '{
      {16'h0011, 3'd1, 1'b0, 1'b0},
      {16'h0011, 3'd2, 1'b0, 1'b0},
      {16'h0011, 3'd3, 1'b0, 1'b0},
      {16'h0011, 3'd4, 1'b1, 1'b0},
      {16'h0011, 3'd5, 1'b1, 1'b0},
      {16'h0019, 3'd5, 1'b1, 1'b0},
      {16'h0011, 3'd6, 1'b1, 1'b0},
      {16'h0011, 3'd7, 1'b1, 1'b0},
      {16'h0011, 3'd7, 1'b1, 1'b0},
      {16'h0022, 3'd1, 1'b0, 1'b0},
      {16'h0011, 3'd7, 1'b1, 1'b0},
      {16'h0011, 3'd7, 1'b1, 1'b1}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ret_valid = 1'b0;
   logic [ADDR_W-1:0] ret_pc = '0;
   logic [HOT_W-1:0]  hot_start = HOT_W'(10);
   logic              ack = 1'b0;
   logic              clear_req = 1'b0;
   logic [IDX_W-1:0]  rd_idx = '0;
   logic              hot_req, busy, rd_valid, rd_cand;
   logic [TAG_W-1:0]  rd_tag;
   logic [CNT_W-1:0]  rd_cnt;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   always #2.5 clk = ~clk;

   hsd_hotspot_detector #(
      .ADDR_W (ADDR_W),
      .DEPTH  (DEPTH),
      .CNT_W  (CNT_W),
      .THRESH (THRESH),
      .WIN_W  (WIN_W),
      .HOT_W  (HOT_W)
   ) i_hsd_hotspot_detector (
      .clk       (clk),
      .rst_n     (rst_n),
      .ret_valid (ret_valid),
      .ret_pc    (ret_pc),
      .hot_start (hot_start),
      .ack       (ack),
      .clear_req (clear_req),
      .rd_idx    (rd_idx),
      .hot_req   (hot_req),
      .busy      (busy),
      .rd_valid  (rd_valid),
      .rd_tag    (rd_tag),
      .rd_cnt    (rd_cnt),
      .rd_cand   (rd_cand)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // one retired branch, outputs settled at the following falling edge
   task automatic send(input logic [ADDR_W-1:0] pc);
      @(negedge clk);
      ret_pc    = pc;
      ret_valid = 1'b1;
      rd_idx    = pc[IDX_W-1:0];
      @(negedge clk);
      ret_valid = 1'b0;
   endtask

   task automatic do_ack();
      @(negedge clk);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rd_idx = 3'd1;
      #1;
      check("R1 hot_req", int'(hot_req), 0);
      check("R1 busy", int'(busy), 0);
      check("R1 valid", int'(rd_valid), 0);
      check("R1 count", int'(rd_cnt), 0);
      rst_n = 1'b1;

      // vector table: counting, saturation, refill, protected candidate, hot
      for (int v = 0; v < NVEC; v++) begin
         send(VECS[v][20:5]);
         check("R2 R3 count", int'(rd_cnt), int'(VECS[v][4:2]));
         check("R4 candidate", int'(rd_cand), int'(VECS[v][1]));
         check("R6 hot_req", int'(hot_req), int'(VECS[v][0]));
      end
      rd_idx = 3'd1;
      #1;
      check("R3 kept tag", int'(rd_tag), 2);
      check("R10 read port valid", int'(rd_valid), 1);

      // R8: frozen while request pending
      send(16'h0011);
      check("R8 frozen count", int'(rd_cnt), 7);
      send(16'h002A);
      check("R8 frozen slot2 tag", int'(rd_tag), 4);
      check("R7 request held", int'(hot_req), 1);

      do_ack();
      check("R7 ack drops request", int'(hot_req), 0);

      // R5: 20 more accepted branches complete the 32-branch window
      for (int k = 0; k < 19; k++) begin
         send((k % 2 == 1) ? 16'h000D : 16'h0005);
      end
      check("R3 refill count", int'(rd_cnt), 1);
      rd_idx = 3'd1;
      #1;
      check("R5 before rollover", int'(rd_cnt), 7);
      send(16'h000D);
      check("R5 slot5 count wiped", int'(rd_cnt), 0);
      check("R5 slot5 still valid", int'(rd_valid), 1);
      rd_idx = 3'd1;
      #1;
      check("R5 slot1 count wiped", int'(rd_cnt), 0);
      check("R5 candidate kept", int'(rd_cand), 1);

      // R8: ret_valid low has no effect
      @(negedge clk);
      ret_pc = 16'h0011;
      @(negedge clk);
      check("R8 valid low", int'(rd_cnt), 0);

      send(16'h0011);
      check("R2 count after rollover", int'(rd_cnt), 1);
      check("R6 no request", int'(hot_req), 0);

      // R9: clear sweep
      @(negedge clk);
      clear_req = 1'b1;
      @(negedge clk);
      clear_req = 1'b0;
      check("R9 busy rises", int'(busy), 1);
      for (int k = 2; k <= 9; k++) begin
         @(negedge clk);
         if (k == 8) ret_valid = 1'b0;
         check("R9 busy length", int'(busy), (k <= 8) ? 1 : 0);
         if (k == 7) begin
            ret_pc    = 16'h0000;
            ret_valid = 1'b1;
         end
      end
      rd_idx = 3'd0;
      #1;
      check("R8 branch ignored while busy", int'(rd_valid), 0);
      rd_idx = 3'd1;
      #1;
      check("R9 slot invalid", int'(rd_valid), 0);
      check("R9 candidate cleared", int'(rd_cand), 0);

      // R6: fresh detection counter, 4 warm-up hits then 5 candidate hits
      for (int k = 0; k < 8; k++) begin
         send(16'h0011);
      end
      check("R6 not yet hot", int'(hot_req), 0);
      send(16'h0011);
      check("R6 reaches zero", int'(hot_req), 1);

      // R9: clear while a request is pending drops it
      @(negedge clk);
      clear_req = 1'b1;
      @(negedge clk);
      clear_req = 1'b0;
      check("R9 clear drops request", int'(hot_req), 0);
      check("R9 busy after clear", int'(busy), 1);
      repeat (DEPTH) @(negedge clk);
      check("R9 busy done", int'(busy), 0);

      finish_run();
   end

endmodule